// File: doc/BRIEF.md
# Integer Shift Unit with 32-bit and 64-bit Forms

This block carries out the integer shifts of a 64-bit datapath: a left shift, a logical right shift and an arithmetic right shift. Each shift comes in two forms. The word form uses a 5-bit count. The extended form uses a 6-bit count and works on the whole doubleword. A decoder presents a source operand and a count operand, which is a register value or an immediate that has already been expanded. It also presents the shift kind, taken from the two low bits of the opcode, and the form flag, taken from the instruction word.

The 32-bit right shifts act on the low word only. The logical form zero-extends the low word before it shifts. The arithmetic form sign-extends the low word from bit 31 before it shifts, so that the sign fills the whole result. The 32-bit left shift works on the full source and leaves the upper half as it falls out of the shift.

The shifter logic is combinational and feeds one output register, so a result appears one clock after its operands are presented.

Top module: `shift_unit`

## Requirements
- R1: A result is registered: `out_valid` is high in the cycle after an `in_valid` cycle and low in the cycle after an idle cycle, and `result` holds the value computed from the inputs of that earlier cycle.
- R2: While `rst_n` is low, `out_valid` and `result` are driven to zero.
- R3: With `ext` = 0, only bits [4:0] of `cnt` set the shift distance, and all higher count bits have no effect on the result.
- R4: With `ext` = 1, only bits [5:0] of `cnt` set the shift distance, and all higher count bits have no effect on the result.
- R5: The word left shift (`op_sel` = 2'b01, `ext` = 0) shifts all 64 source bits left and fills with zeros; the upper half of the source is not cleared first.
- R6: The word logical right shift (`op_sel` = 2'b10, `ext` = 0) clears source bits [63:32], then shifts right with zero fill, so result bits [63:32] are always zero.
- R7: The word arithmetic right shift (`op_sel` = 2'b11, `ext` = 0) treats source bits [31:0] as a signed word, shifts it right, and copies bit 31 of the shifted word into result bits [63:31].
- R8: The doubleword left shift and logical right shift (`op_sel` = 2'b01 or 2'b10, `ext` = 1) act on the full 64-bit source with zero fill.
- R9: The doubleword arithmetic right shift (`op_sel` = 2'b11, `ext` = 1) treats the full source as signed and fills from bit 63.
- R10: The value `op_sel` = 2'b00 does not select a shift, and it produces a zero result.
- R11: A masked count of zero passes the source through unchanged, except that the word right shifts still zero-extend or sign-extend the low word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| op_sel | input | 2 | 01 left, 10 logical right, 11 arithmetic right, 00 none |
| ext | input | 1 | 1 = 64-bit form with a 6-bit count, 0 = 32-bit form with a 5-bit count |
| src | input | 64 | Source operand |
| cnt | input | 64 | Count operand; only the low bits are used |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted value |

## Verification
On every cycle, the assertions check the one-cycle valid timing. For every word right shift, they check the shape of the upper half: all zeros after a logical shift, and copies of bit 31 after an arithmetic shift. They also check that a reserved select gives zero and that a zero-count doubleword left shift passes the source through. Only the bench's scenarios can show the exact shifted values. These include the claim that count bits above the mask have no effect, since the bench sets those bits to random non-zero values while it sweeps every count from 0 to 63 for each kind and form. The reset state and the behaviour of a reset in the middle of a run are also shown by the bench alone.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic            ext,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] cnt,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN);

  logic [CW-1:0]   amt;
  logic [XLEN-1:0] lo_zext, lo_sext, shl, shr_l, shr_a, nxt;

  // distance masked by form: 5 bits for a word, 6 for a doubleword
  assign amt     = ext ? cnt[CW-1:0] : {1'b0, cnt[CW-2:0]};
  assign lo_zext = {{HALF{1'b0}}, src[HALF-1:0]};
  assign lo_sext = {{HALF{src[HALF-1]}}, src[HALF-1:0]};

  assign shl   = src << amt;
  assign shr_l = (ext ? src : lo_zext) >> amt;
  assign shr_a = $signed(ext ? src : lo_sext) >>> amt;

  always_comb begin
    case (op_sel)
      2'b01:   nxt = shl;
      2'b10:   nxt = shr_l;
      2'b11:   nxt = shr_a;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      result    <= in_valid ? nxt : result;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  lsr_word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'b10 && !$past(ext)) |-> (result[XLEN-1:HALF] == '0));

  // R7
  asr_word_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'b11 && !$past(ext))
      |-> ((&result[XLEN-1:HALF-1]) || !(|result[XLEN-1:HALF-1])));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'b00) |-> (result == '0));

  // R11
  zero_count_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 2'b01 && $past(ext) && $past(cnt[CW-1:0]) == '0)
      |-> (result == $past(src)));
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic        ext;
  logic [63:0] src, cnt;
  logic        out_valid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  shift_unit u_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .ext(ext),
    .src(src), .cnt(cnt), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [1:0] op, input logic e,
                                        input logic [63:0] s, input logic [63:0] c);
    int d;
    logic [63:0] w, r;
    logic fill;
    d = e ? int'(c[5:0]) : int'(c[4:0]);
    r = '0;
    if (op == 2'b01) begin
      for (int i = 0; i < 64; i++) r[i] = (i >= d) ? s[i-d] : 1'b0;
    end else if (op != 2'b00) begin
      w = s;
      if (!e) for (int i = 32; i < 64; i++) w[i] = (op == 2'b11) ? s[31] : 1'b0;
      fill = (op == 2'b11) ? w[63] : 1'b0;
      for (int i = 0; i < 64; i++) r[i] = (i + d < 64) ? w[i+d] : fill;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic e, input logic [63:0] s,
                       input logic [63:0] c, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; ext = e; src = s; cnt = c;
    exp_q.push_back(model(op, e, s, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_sel = $urandom; src = {$urandom, $urandom};
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result === e, t, result, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tg;
    rst_n = 1'b0; in_valid = 1'b1; op_sel = 2'b01; ext = 1'b1;
    src = 64'hFFFF_FFFF_FFFF_FFFF; cnt = 64'd0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R2 reset out_valid", {63'd0, out_valid}, 64'd0);
    check(result === 64'd0, "R2 reset result", result, 64'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    idle(2);

    // R11 zero counts, R10 reserved select, R7 sign cases
    drive(2'b01, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_0000_0040, "R11 R4 sllx zero");
    drive(2'b10, 1'b0, 64'hDEAD_BEEF_8000_0001, 64'h20, "R11 R6 srl zero");
    drive(2'b11, 1'b0, 64'h0000_0000_8000_0001, 64'h0, "R11 R7 sra zero");
    drive(2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, "R10 reserved");
    drive(2'b11, 1'b0, 64'h7FFF_FFFF_8000_0000, 64'h1F, "R7 sra 31");
    drive(2'b11, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h4, "R7 sra positive");
    drive(2'b01, 1'b0, 64'h8000_0000_8000_0001, 64'h1, "R5 sll upper kept");
    drive(2'b11, 1'b1, 64'h8000_0000_0000_0000, 64'h3F, "R9 srax 63");
    idle(3);

    for (int e = 0; e < 2; e++)
      for (int op = 1; op < 4; op++)
        for (int c = 0; c < 64; c++)
          for (int k = 0; k < 3; k++) begin
            logic [63:0] cc;
            cc = {$urandom, $urandom} & ~64'h3F;
            if (cc == 0) cc = 64'h40;
            cc = cc | c;
            if (e == 0) tg = (op == 1) ? "R3 R5 sll" : (op == 2) ? "R3 R6 srl" : "R3 R7 sra";
            else        tg = (op == 3) ? "R4 R9 srax" : "R4 R8 sllx/srlx";
            drive(op[1:0], e[0], {$urandom, $urandom}, cc, tg);
            if (($urandom % 8) == 0) idle(1);
          end
    idle(3);
    check(exp_q.size() == 0, "R1 all results delivered", exp_q.size(), 64'd0);

    drive(2'b10, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'h4, "R8 srlx before reset");
    idle(2);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && result === 64'd0, "R2 mid-run reset", result, 64'd0);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule